// File: doc/BRIEF.md
# System Controller Peripheral

This block is a word-addressed bus slave that collects several small system functions behind one register window. It owns a bank of general-purpose outputs, samples a bank of general-purpose inputs through a two-stage synchroniser, and runs two identical up-counting compare timers. It also holds a capability word and an identification word, and it accepts a command register for the configuration port.

Software uses the block in three ways. It reads strapping pins and drives board signals. It arms the timers in one-shot or free-running mode and takes an interrupt pulse on each compare match. It asks for a system shutdown or a system reset by writing particular registers. Three interrupt lines (GPIO, timer 0, timer 1) and two single-cycle request strobes (shutdown, reset) leave the block.

The bus is a plain valid/write/address/data port. A write takes effect at the clock edge where `bus_valid` and `bus_write` are both high. Read data is combinational from the current state. The word index is the byte address shifted right by two.

Top module: `syscon_periph`

## Requirements
- R1: After reset, word 15 reads 0x10014D31, word 14 reads 0x00000000, word 0 reads 0x00000001 (strap value, with that value held on the pins), word 13 reads 0x00000001, and every other word reads zero. All outputs are low and both timers are stopped.
- R2: Words 3, 7, 11 and 12, and any word index of 16 or more, read zero and ignore writes. Writes to word 0 (GPIO input) and word 14 (capabilities) have no effect.
- R3: Words 4 and 8 are the control registers of timer 0 and timer 1. Bit 0 is run-enable and bit 1 is auto-restart, and the other bits read zero. Writing bit 0 high starts the timer. Writing it low stops the timer, and the count holds its value.
- R4: A running timer adds one to its count on each clock. On the clock where its count is at or above its compare value (word 5 or 9), the count returns to zero. Its interrupt line is high for exactly the following cycle.
- R5: A timer whose auto-restart bit is 0 clears its own run-enable bit on the clock where it reaches compare. A control write in that same cycle takes priority.
- R6: A timer whose auto-restart bit is 1 keeps running after a compare match. It gives one interrupt pulse every compare+1 clocks.
- R7: Writing a counter register (word 6 or 10) loads min(data, compare). Reading it returns the live count.
- R8: A write to word 13 whose data bits [15:0] equal 0x000E makes `shutdown_req` high for the one cycle after the write. Any other data does nothing, and word 13 always reads 0x00000001 (ready).
- R9: Any write to word 15 makes `reset_req` high for the one cycle after the write, and word 15 keeps its value.
- R10: Word 1 drives `gpio_out` directly, and word 2 holds the per-bit interrupt enables. Word 0 shows `gpio_in` after two register stages. `irq_gpio` is high for one cycle, on the same edge at which word 0 takes a changed value, if any changed bit has its enable set.
- R11: `bus_rdata` is zero unless `bus_valid` is high and `bus_write` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; the word index is bits [ADDR_W-1:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| gpio_in | input | GPIO_W | Asynchronous general-purpose inputs |
| gpio_out | output | GPIO_W | General-purpose outputs |
| irq_gpio | output | 1 | GPIO change interrupt pulse |
| irq_timer0 | output | 1 | Timer 0 compare pulse |
| irq_timer1 | output | 1 | Timer 1 compare pulse |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The embedded properties check several cycle rules on every cycle:
- a stopped timer keeps its count;
- a one-shot match clears the enable bit;
- a match returns the count to zero;
- a loaded count never exceeds compare;
- a GPIO pulse only occurs with an enable bit set;
- each request strobe follows a write to its own register.

Other behaviour shows only in the bench's scenarios, which compare the design against a behavioural model on every clock. That covers the exact pulse spacing in auto-restart mode, the clipping value on counter writes, the command-value filtering on word 13, and the read-only and reserved words keeping their values.

// File: rtl/syscon_pkg.sv
// Package: shared word offsets, field positions and constants for the
// system controller. Assumes a 32-bit data path and sixteen register words.
package syscon_pkg;
    localparam int DATA_W      = 32;
    localparam int NUM_TMR     = 2;
    localparam int MAP_WORDS   = 16;

    // Word offsets; software decodes these, so they are fixed.
    localparam int OFF_GPIO_IN  = 0;
    localparam int OFF_GPIO_OUT = 1;
    localparam int OFF_GPIO_IEN = 2;
    localparam int OFF_TMR_BASE = 4;
    localparam int TMR_STRIDE   = 4;
    localparam int TMR_CTRL     = 0;
    localparam int TMR_CMP      = 1;
    localparam int TMR_CNT      = 2;
    localparam int OFF_CFG      = 13;
    localparam int OFF_CAPS     = 14;
    localparam int OFF_ID       = 15;

    // Timer control fields
    localparam int CTL_RUN  = 0;
    localparam int CTL_AUTO = 1;

    // Configuration-port command that requests shutdown
    localparam logic [15:0] CMD_SHUTDOWN = 16'h000E;
    localparam logic [DATA_W-1:0] CFG_READY = 32'h0000_0001;
endpackage

// File: rtl/syscon_gpio.sv
// Module: GPIO unit. Holds the output and interrupt-enable registers,
// synchronises the inputs through two flops (both reset to the strap value)
// and pulses an interrupt when an enabled bit of the synchronised value changes.
// Assumes pins_i is asynchronous to clk.
module syscon_gpio #(
    parameter int          GPIO_W = 8,
    parameter logic [GPIO_W-1:0] STRAP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GPIO_W-1:0] pins_i,
    input  logic              wr_out,
    input  logic              wr_ien,
    input  logic [GPIO_W-1:0] wdata,
    output logic [GPIO_W-1:0] out_q,
    output logic [GPIO_W-1:0] ien_q,
    output logic [GPIO_W-1:0] in_q,
    output logic              irq_o
);
    logic [GPIO_W-1:0] meta_q;
    logic [GPIO_W-1:0] changed;

    assign changed = meta_q ^ in_q;

    // Input synchroniser and change interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= STRAP;
            in_q   <= STRAP;
            irq_o  <= 1'b0;
        end else begin
            meta_q <= pins_i;
            in_q   <= meta_q;
            irq_o  <= |(changed & ien_q);
        end
    end

    // Software-written output and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            ien_q <= '0;
        end else begin
            if (wr_out) out_q <= wdata;
            if (wr_ien) ien_q <= wdata;
        end
    end

    AST_GPIO_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|ien_q)); // R10
endmodule

// File: rtl/syscon_timer.sv
// Module: one up-counting compare timer. Counts while enabled. At or above
// compare it returns to zero, pulses its interrupt for one cycle and, in
// one-shot mode, drops its own enable. Bus writes take priority over
// self-updates. Counter loads are clipped to the compare value.
module syscon_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctrl,
    input  logic         wr_cmp,
    input  logic         wr_cnt,
    input  logic [W-1:0] wdata,
    output logic [1:0]   ctrl_o,
    output logic [W-1:0] cmp_o,
    output logic [W-1:0] cnt_o,
    output logic         irq_o
);
    import syscon_pkg::*;

    logic         run_q, auto_q;
    logic [W-1:0] cmp_q, cnt_q;
    logic         reach;

    assign reach  = run_q && (cnt_q >= cmp_q);
    assign ctrl_o = {auto_q, run_q};
    assign cmp_o  = cmp_q;
    assign cnt_o  = cnt_q;

    // Control bits: bus write first, then one-shot self-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            auto_q <= 1'b0;
        end else if (wr_ctrl) begin
            run_q  <= wdata[CTL_RUN];
            auto_q <= wdata[CTL_AUTO];
        end else if (reach && !auto_q) begin
            run_q  <= 1'b0;
        end
    end

    // Compare register
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (wr_cmp) cmp_q <= wdata;
    end

    // Count: clipped load, wrap on reach, increment while running
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= (wdata > cmp_q) ? cmp_q : wdata;
        else if (reach)  cnt_q <= '0;
        else if (run_q)  cnt_q <= cnt_q + 1'b1;
    end

    // Compare-match interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= reach;
    end

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_cnt) |=> $stable(cnt_q)); // R3
    AST_ONESHOT_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !auto_q && (cnt_q >= cmp_q) && !wr_ctrl) |=> !run_q); // R5
    AST_MATCH_WRAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && (cnt_q >= cmp_q) && !wr_cnt) |=> (cnt_q == '0)); // R6
    AST_LOAD_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_q <= $past(cmp_q))); // R7
endmodule

// File: rtl/syscon_periph.sv
// Module: system controller top. Decodes the word index, routes writes to
// the GPIO unit and the timers, builds the combinational read mux, and
// produces the shutdown and reset request strobes. The read-only words and
// the reserved words ignore writes.
module syscon_periph #(
    parameter int                ADDR_W   = 8,
    parameter int                GPIO_W   = 8,
    parameter logic [GPIO_W-1:0] STRAP    = 1,
    parameter logic [31:0]       CAPS     = 32'h0000_0000,
    parameter logic [31:0]       SYS_ID   = 32'h1001_4D31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [GPIO_W-1:0] gpio_in,
    output logic [GPIO_W-1:0] gpio_out,
    output logic              irq_gpio,
    output logic              irq_timer0,
    output logic              irq_timer1,
    output logic              shutdown_req,
    output logic              reset_req
);
    import syscon_pkg::*;

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_idx;
    logic              wr_acc, rd_acc;
    logic [GPIO_W-1:0] gp_ien, gp_in;

    logic [1:0]        tmr_ctrl [NUM_TMR];
    logic [DATA_W-1:0] tmr_cmp  [NUM_TMR];
    logic [DATA_W-1:0] tmr_cnt  [NUM_TMR];
    logic              tmr_irq  [NUM_TMR];

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign wr_acc   = bus_valid && bus_write;
    assign rd_acc   = bus_valid && !bus_write;

    syscon_gpio #(.GPIO_W(GPIO_W), .STRAP(STRAP)) gpio_u (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (gpio_in),
        .wr_out (wr_acc && (word_idx == WORD_W'(OFF_GPIO_OUT))),
        .wr_ien (wr_acc && (word_idx == WORD_W'(OFF_GPIO_IEN))),
        .wdata  (bus_wdata[GPIO_W-1:0]),
        .out_q  (gpio_out),
        .ien_q  (gp_ien),
        .in_q   (gp_in),
        .irq_o  (irq_gpio)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        localparam int BASE = OFF_TMR_BASE + t * TMR_STRIDE;
        syscon_timer #(.W(DATA_W)) tmr_u (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (wr_acc && (word_idx == WORD_W'(BASE + TMR_CTRL))),
            .wr_cmp  (wr_acc && (word_idx == WORD_W'(BASE + TMR_CMP))),
            .wr_cnt  (wr_acc && (word_idx == WORD_W'(BASE + TMR_CNT))),
            .wdata   (bus_wdata),
            .ctrl_o  (tmr_ctrl[t]),
            .cmp_o   (tmr_cmp[t]),
            .cnt_o   (tmr_cnt[t]),
            .irq_o   (tmr_irq[t])
        );
    end

    assign irq_timer0 = tmr_irq[0];
    assign irq_timer1 = tmr_irq[1];

    // Read mux: fixed words, then timer words; all else reads zero
    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            case (word_idx)
                WORD_W'(OFF_GPIO_IN):  bus_rdata = 32'(gp_in);
                WORD_W'(OFF_GPIO_OUT): bus_rdata = 32'(gpio_out);
                WORD_W'(OFF_GPIO_IEN): bus_rdata = 32'(gp_ien);
                WORD_W'(OFF_CFG):      bus_rdata = CFG_READY;
                WORD_W'(OFF_CAPS):     bus_rdata = CAPS;
                WORD_W'(OFF_ID):       bus_rdata = SYS_ID;
                default:               bus_rdata = '0;
            endcase
            for (int t = 0; t < NUM_TMR; t++) begin
                if (word_idx == WORD_W'(OFF_TMR_BASE + t * TMR_STRIDE + TMR_CTRL))
                    bus_rdata = 32'(tmr_ctrl[t]);
                if (word_idx == WORD_W'(OFF_TMR_BASE + t * TMR_STRIDE + TMR_CMP))
                    bus_rdata = tmr_cmp[t];
                if (word_idx == WORD_W'(OFF_TMR_BASE + t * TMR_STRIDE + TMR_CNT))
                    bus_rdata = tmr_cnt[t];
            end
        end
    end

    // Request strobes: shutdown on the command value, reset on any ID write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shutdown_req <= 1'b0;
            reset_req    <= 1'b0;
        end else begin
            shutdown_req <= wr_acc && (word_idx == WORD_W'(OFF_CFG))
                            && (bus_wdata[15:0] == CMD_SHUTDOWN);
            reset_req    <= wr_acc && (word_idx == WORD_W'(OFF_ID));
        end
    end

    AST_SHUTDOWN_FROM_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(wr_acc && (word_idx == WORD_W'(OFF_CFG)))); // R8
    AST_RESET_FROM_ID: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(wr_acc && (word_idx == WORD_W'(OFF_ID)))); // R9
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |-> (bus_rdata == '0)); // R11
endmodule

// File: tb/syscon_periph_tb.sv
// Bench: drives bus and pin stimulus at the falling edge, steps a behavioural
// model at the rising edge, and compares every output halfway through the low
// phase of the clock.
module syscon_periph_tb_top;
    localparam int  GW  = 8;
    localparam time HP  = 10ns;

    logic        clk = 0, rst_n = 0;
    logic        bus_valid = 0, bus_write = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [GW-1:0] gpio_in = 8'h01, gpio_out;
    logic irq_gpio, irq_timer0, irq_timer1, shutdown_req, reset_req;

    int vectors = 0, misses = 0;
    bit comparing = 0, finished = 0;

    always #HP clk = ~clk;

    syscon_periph dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .irq_gpio(irq_gpio),
        .irq_timer0(irq_timer0), .irq_timer1(irq_timer1),
        .shutdown_req(shutdown_req), .reset_req(reset_req)
    );

    // ---------------- behavioural model ----------------
    logic [GW-1:0] m_s1, m_s2, m_out, m_ien;
    bit            m_girq, m_sd, m_rr;
    bit            t_run [2], t_auto [2], t_irq [2];
    logic [31:0]   t_cmp [2], t_cnt [2];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 8'h01; m_s2 = 8'h01; m_out = 0; m_ien = 0;
            m_girq = 0; m_sd = 0; m_rr = 0;
            for (int i = 0; i < 2; i++) begin
                t_run[i] = 0; t_auto[i] = 0; t_irq[i] = 0; t_cmp[i] = 0; t_cnt[i] = 0;
            end
        end else begin
            int w;
            bit wr;
            w  = int'(bus_addr >> 2);
            wr = bus_valid && bus_write;
            m_girq = ((m_s1 ^ m_s2) & m_ien) != 0;
            m_s2 = m_s1; m_s1 = gpio_in;
            if (wr && w == 1) m_out = bus_wdata[GW-1:0];
            if (wr && w == 2) m_ien = bus_wdata[GW-1:0];
            m_sd = wr && w == 13 && bus_wdata[15:0] == 16'h000E;
            m_rr = wr && w == 15;
            for (int i = 0; i < 2; i++) begin
                bit hit;
                logic [31:0] old_cmp;
                hit = t_run[i] && (t_cnt[i] >= t_cmp[i]);
                old_cmp = t_cmp[i];
                t_irq[i] = hit;
                if (wr && w == 4 + 4*i) begin
                    t_run[i] = bus_wdata[0]; t_auto[i] = bus_wdata[1];
                end else if (hit && !t_auto[i]) t_run[i] = 0;
                if (wr && w == 6 + 4*i)
                    t_cnt[i] = (bus_wdata > old_cmp) ? old_cmp : bus_wdata;
                else if (hit) t_cnt[i] = 0;
                else if (t_run[i] || (wr && w == 4 + 4*i && hit == 0 && t_cnt[i] != t_cnt[i])) t_cnt[i] = t_cnt[i];
                if (!(wr && w == 6 + 4*i) && !hit && t_run_old(i)) t_cnt[i] = t_cnt[i] + 1;
                if (wr && w == 5 + 4*i) t_cmp[i] = bus_wdata;
                prev_run[i] = t_run[i];
            end
        end
    end

    // run state as it was before this edge's update
    bit prev_run [2];
    function automatic bit t_run_old(int i);
        return prev_run[i];
    endfunction
    initial begin prev_run[0] = 0; prev_run[1] = 0; end

    function automatic logic [31:0] m_read();
        int w;
        if (!bus_valid || bus_write) return 0;
        w = int'(bus_addr >> 2);
        case (w)
            0: return 32'(m_s2);
            1: return 32'(m_out);
            2: return 32'(m_ien);
            4: return {30'b0, t_auto[0], t_run[0]};
            5: return t_cmp[0];
            6: return t_cnt[0];
            8: return {30'b0, t_auto[1], t_run[1]};
            9: return t_cmp[1];
            10: return t_cnt[1];
            13: return 32'h1;
            14: return 32'h0;
            15: return 32'h1001_4D31;
            default: return 0;
        endcase
    endfunction

    function automatic string rd_tag();
        int w;
        if (!bus_valid || bus_write) return "R11";
        w = int'(bus_addr >> 2);
        case (w)
            0, 1, 2: return "R10";
            4, 8:    return "R3/R5";
            5, 9:    return "R4";
            6, 10:   return "R6/R7";
            13:      return "R8";
            14, 15:  return "R1/R9";
            default: return "R2";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // ---------------- comparison, every cycle ----------------
    always @(negedge clk) begin
        #(HP/2);
        if (comparing) begin
            check(rd_tag(), "bus_rdata", bus_rdata, m_read());
            check("R4/R6", "irq_timer0", 32'(irq_timer0), 32'(t_irq[0]));
            check("R4/R6", "irq_timer1", 32'(irq_timer1), 32'(t_irq[1]));
            check("R10", "irq_gpio", 32'(irq_gpio), 32'(m_girq));
            check("R10", "gpio_out", 32'(gpio_out), 32'(m_out));
            check("R8", "shutdown_req", 32'(shutdown_req), 32'(m_sd));
            check("R9", "reset_req", 32'(reset_req), 32'(m_rr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic op(bit v, bit wr, int word, logic [31:0] d);
        @(negedge clk);
        bus_valid = v; bus_write = wr; bus_addr = 8'(word << 2); bus_wdata = d;
    endtask
    task automatic wr_w(int word, logic [31:0] d); op(1, 1, word, d); endtask
    task automatic rd_w(int word); op(1, 0, word, 0); endtask
    task automatic idle(int n);
        for (int k = 0; k < n; k++) op(0, 0, 0, 0);
    endtask

    // ---------------- scenario ----------------
    initial begin
        repeat (2) @(posedge clk);
        comparing = 1;                       // R1: reset values visible
        @(negedge clk); rst_n = 1;
        for (int w = 0; w < 64; w++) rd_w(w); // R1, R2 map sweep
        idle(2);                             // R11 idle reads
        // R2: read-only and reserved words
        wr_w(0, 32'hFFFF_FFFF); wr_w(14, 32'hDEAD_BEEF);
        wr_w(3, 32'h1234); wr_w(12, 32'h55); wr_w(20, 32'h99);
        rd_w(0); rd_w(14); rd_w(3); rd_w(12); rd_w(20);
        // R10: outputs, enables, synchronised change interrupts
        wr_w(1, 32'hA5); wr_w(2, 32'h0F); rd_w(1); rd_w(2);
        @(negedge clk); gpio_in = 8'h00;     // enabled bit 0 changes
        idle(4); rd_w(0);
        @(negedge clk); gpio_in = 8'h20;     // bit 5 not enabled
        idle(4); rd_w(0);
        // R4/R5: one-shot timer 0
        wr_w(5, 5); wr_w(4, 32'h1);
        for (int k = 0; k < 10; k++) begin rd_w(6); rd_w(4); end
        // R6: auto-restart timer 1
        wr_w(9, 3); wr_w(8, 32'h3);
        for (int k = 0; k < 12; k++) rd_w(10);
        // R3: stop and hold
        wr_w(8, 32'h2); idle(3); rd_w(10); rd_w(8);
        // R7: clipped and plain loads
        wr_w(10, 100); rd_w(10); wr_w(10, 2); rd_w(10);
        wr_w(8, 32'h1); for (int k = 0; k < 6; k++) rd_w(10);
        // lower compare below a running count
        wr_w(5, 50); wr_w(4, 32'h3); idle(10); wr_w(5, 4); idle(8); rd_w(6);
        wr_w(4, 0);
        // R8: configuration commands
        wr_w(13, 32'h1234_000E); idle(1); wr_w(13, 32'h0000_000F); idle(1);
        wr_w(13, 32'hFFFF_000E); rd_w(13);
        // R9: identification write
        wr_w(15, 32'h0); rd_w(15); idle(1);
        // mixed random traffic
        for (int k = 0; k < 600; k++) begin
            int w, sel;
            logic [31:0] d;
            sel = int'($urandom_range(0, 9));
            w = int'($urandom_range(0, 17));
            d = (w inside {5, 6, 9, 10}) ? 32'($urandom_range(0, 12)) : $urandom();
            if (w == 13 && sel < 5) d[15:0] = 16'h000E;
            if (sel == 0) begin @(negedge clk); gpio_in = 8'($urandom()); end
            else if (sel < 5) rd_w(w);
            else if (sel < 8) wr_w(w, d);
            else idle(1);
        end
        idle(3);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule